// File: doc/BRIEF.md
# 24-bit Serial Frame Receiver with Chaining

This block is the receiving end of a write-only three-wire serial link. It watches a serial clock, an active-low select and a data line. With select low, it shifts in one bit on every falling serial-clock edge, most significant bit first. When twenty-four bits have arrived, it hands the whole word to downstream logic on a parallel bus with a one-cycle strobe. The word's upper eight bits are the command and its lower sixteen bits are the data. Decoding the command is left to the logic behind the bus.

All three serial lines are brought into a faster system clock through multi-flop synchronizers, and edges are found in that domain. The system clock must run at least four times faster than the serial clock. A frame that stops short, because select rises before the twenty-fourth edge, is dropped without a trace. Bits that arrive after the twenty-fourth edge in the same select window are not taken.

After its own twenty-fourth edge the block pulls an active-low chain output low, and holds it there until select is released. Several receivers can therefore be daisy-chained: each one's chain output drives the next one's select, and the serial clock and data lines are shared. A static enable input keeps the chain output parked high when chaining is not wanted.

Top module: `serial_frame_rx`

## Requirements
- R1: Bits are taken on falling serial-clock edges while select is low, first bit into frame_o[23]; frame_o[23:16] is the command byte and frame_o[15:0] the data word.
- R2: frame_vld_o is high for exactly one system clock per completed frame, in the cycle frame_o first shows that frame.
- R3: Falling edges after the 24th within one select-low window produce no further strobe and leave frame_o unchanged.
- R4: If select rises before 24 bits, no strobe is issued, and the next frame is assembled from an empty register.
- R5: With chain_en_i = 1, chain_n_o goes low after the 24th falling edge and stays low while select remains low.
- R6: chain_n_o returns high once select is high.
- R7: With chain_en_i = 0, chain_n_o stays high at all times.
- R8: Serial-clock edges while select is high are not counted, and the idle serial-clock level (high or low) does not affect reception.
- R9: While reset is held and right after it, frame_vld_o is 0 and chain_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low frame select, asynchronous |
| din_i | input | 1 | Serial data, asynchronous |
| chain_en_i | input | 1 | Static enable for the chain output |
| frame_o | output | 24 | Last completed frame: command in [23:16], data in [15:0] |
| frame_vld_o | output | 1 | One-cycle strobe when frame_o is loaded |
| chain_n_o | output | 1 | Active-low select for the next device in a chain |

## Verification
The embedded properties check every cycle that the strobe never lasts more than one cycle, that the bit counter never runs past the frame length, that no strobe follows an edge taken after the frame has completed, and that the chain output is high whenever select is high or chaining is disabled. Only the bench's scenarios can show that the assembled words carry the right bit order and field split. The scenarios are also needed to show that short frames vanish and that surplus bits are dropped. Finally, they show that stray edges outside select and either idle clock level leave reception intact. For this, the bench compares each strobed word against a queue of words predicted from the serial stimulus.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int DEF_FRAME_BITS  = 24;
  localparam int DEF_CMD_BITS    = 8;
  localparam int DEF_SYNC_STAGES = 2;

  // Index of the synchronized serial lines inside the sync vector.
  localparam int IDX_SCLK = 0;
  localparam int IDX_CSN  = 1;
  localparam int IDX_DIN  = 2;
  localparam int N_LINES  = 3;
endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/sfr_edge.sv
module sfr_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic fall,
  output logic rise
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= sig;
  end

  assign fall = prev_q & ~sig;
  assign rise = ~prev_q & sig;
endmodule

// File: rtl/sfr_assembler.sv
module sfr_assembler #(
  parameter int FRAME_BITS = 24
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_low,
  input  logic                  cs_fall,
  input  logic                  sclk_fall,
  input  logic                  din,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_vld_o,
  output logic                  done_o
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(FRAME_BITS - 1);

  logic [CW-1:0]         cnt_q, cnt_base, cnt_nxt;
  logic [FRAME_BITS-1:0] sh_q, sh_base, sh_nxt;
  logic                  done_q, done_base, done_nxt;
  logic                  take, last;

  always_comb begin
    cnt_base  = cs_fall ? '0   : cnt_q;
    sh_base   = cs_fall ? '0   : sh_q;
    done_base = cs_fall ? 1'b0 : done_q;
    take      = cs_low && sclk_fall && !done_base;
    sh_nxt    = take ? {sh_base[FRAME_BITS-2:0], din} : sh_base;
    cnt_nxt   = take ? cnt_base + CW'(1) : cnt_base;
    last      = take && (cnt_base == LAST_IDX);
    done_nxt  = cs_low && (done_base || last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q       <= '0;
      sh_q        <= '0;
      done_q      <= 1'b0;
      frame_o     <= '0;
      frame_vld_o <= 1'b0;
    end else begin
      cnt_q       <= cnt_nxt;
      sh_q        <= sh_nxt;
      done_q      <= done_nxt;
      frame_vld_o <= last;
      if (last) frame_o <= sh_nxt;
    end
  end

  assign done_o = done_q;

  // R2: the strobe lasts a single cycle
  p_vld_single_r2: assert property (@(posedge clk) disable iff (rst)
    frame_vld_o |=> !frame_vld_o);

  // R3: the counter never passes the frame length
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(FRAME_BITS));

  // R3: an edge arriving after completion within the window gives no strobe
  p_no_extra_vld_r3: assert property (@(posedge clk) disable iff (rst)
    (done_q && cs_low && !cs_fall && sclk_fall) |=> !frame_vld_o);

  // R2: a strobe is always accompanied by the completed flag
  p_vld_done_r2: assert property (@(posedge clk) disable iff (rst)
    frame_vld_o |-> done_q || !$past(cs_low));
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import sfr_pkg::*;
#(
  parameter int FRAME_BITS  = DEF_FRAME_BITS,
  parameter int CMD_BITS    = DEF_CMD_BITS,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sclk_i,
  input  logic                  csn_i,
  input  logic                  din_i,
  input  logic                  chain_en_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_vld_o,
  output logic                  chain_n_o
);
  localparam int DATA_BITS = FRAME_BITS - CMD_BITS;
  localparam logic [N_LINES-1:0] SYNC_RST = N_LINES'(1) << IDX_CSN;

  logic [N_LINES-1:0] raw, synced;
  logic sclk_s, csn_s, din_s;
  logic sclk_fall, sclk_rise, cs_fall, cs_rise, cs_low;
  logic done;

  always_comb begin
    raw           = '0;
    raw[IDX_SCLK] = sclk_i;
    raw[IDX_CSN]  = csn_i;
    raw[IDX_DIN]  = din_i;
  end

  sfr_sync #(.W(N_LINES), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  assign sclk_s = synced[IDX_SCLK];
  assign csn_s  = synced[IDX_CSN];
  assign din_s  = synced[IDX_DIN];
  assign cs_low = ~csn_s;

  sfr_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst(rst), .sig(sclk_s), .fall(sclk_fall), .rise(sclk_rise)
  );

  sfr_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst(rst), .sig(csn_s), .fall(cs_fall), .rise(cs_rise)
  );

  sfr_assembler #(.FRAME_BITS(FRAME_BITS)) u_asm (
    .clk(clk), .rst(rst), .cs_low(cs_low), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .din(din_s),
    .frame_o(frame_o), .frame_vld_o(frame_vld_o), .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst) chain_n_o <= 1'b1;
    else     chain_n_o <= !(chain_en_i && done && cs_low);
  end

  if (DATA_BITS < 1) begin : g_bad_split
    initial $error("frame must hold at least one data bit");
  end

  // R6: select high forces the chain output high on the next cycle
  p_chain_idle_r6: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> chain_n_o);

  // R7: disabled chaining keeps the output high
  p_chain_off_r7: assert property (@(posedge clk) disable iff (rst)
    !chain_en_i |=> chain_n_o);

  // R5: the chain output only drops together with or after a completed frame
  p_chain_after_frame_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(chain_n_o) |-> $past(done));

  // R8: a serial clock edge while select is high gives no strobe
  p_no_vld_cs_high_r8: assert property (@(posedge clk) disable iff (rst)
    (csn_s && !cs_rise && sclk_fall) |=> !frame_vld_o);
endmodule

// File: tb/serial_frame_rx_tb.sv
module serial_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk_i = 1'b0, csn_i = 1'b1, din_i = 1'b0, chain_en_i = 1'b1;
  logic [23:0] frame_o;
  logic        frame_vld_o, chain_n_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [23:0] exp_q [$];

  always #4 clk = ~clk;

  serial_frame_rx u_dut (
    .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i), .din_i(din_i),
    .chain_en_i(chain_en_i), .frame_o(frame_o), .frame_vld_o(frame_vld_o),
    .chain_n_o(chain_n_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  // Sends nbits of word, MSB (bit nbits-1) first. R8: toggles SCLK while select is high first.
  task automatic send(input int nbits, input logic [31:0] word, input logic idle_hi);
    sclk_i = ~idle_hi; half();
    sclk_i = idle_hi;  half();
    csn_i = 1'b0; half();
    if (nbits >= 24) exp_q.push_back(24'(word >> (nbits - 24)));
    for (int i = nbits - 1; i >= 0; i--) begin
      din_i = word[i];
      sclk_i = 1'b1; half();
      sclk_i = 1'b0; half();
    end
    sclk_i = idle_hi;
    repeat (4) @(negedge clk);
    // R5 / R7: chain output while select still low
    check(nbits >= 24 ? (chain_en_i ? "R5" : "R7") : "R4",
          32'(chain_n_o), (nbits >= 24 && chain_en_i) ? 32'd0 : 32'd1);
    csn_i = 1'b1;
    repeat (8) @(negedge clk);
    check("R6", 32'(chain_n_o), 32'd1);
  endtask

  // Scoreboard monitor: R1, R2, R3, R4
  always @(negedge clk) begin
    if (!rst && frame_vld_o) begin
      if (exp_q.size() == 0) begin
        check("R3/R4 unexpected strobe", 32'(frame_o), 32'hFFFFFFFF);
      end else begin
        check("R1", 32'(frame_o), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", 32'(frame_vld_o), 32'd0);
    check("R9", 32'(chain_n_o), 32'd1);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R9", 32'(chain_n_o), 32'd1);

    send(24, 32'h00A53C96, 1'b0);           // R1 idle low
    send(24, 32'h0001FFFF, 1'b1);           // R8 idle high
    send(10, 32'h000003FF, 1'b0);           // R4 short frame dropped
    send(24, 32'h00800001, 1'b0);           // R4 fresh assembly after drop
    send(30, 32'h3ABCDEF5, 1'b1);           // R3 surplus bits ignored
    check("R3", 32'(frame_o), 32'(24'(32'h3ABCDEF5 >> 6)));
    chain_en_i = 1'b0;
    send(24, 32'h00030000, 1'b0);           // R7 chain disabled
    chain_en_i = 1'b1;
    send(24, 32'h00000000, 1'b1);           // R1 all zero
    send(24, 32'h00FFFFFF, 1'b0);           // R1 all ones
    repeat (10) @(negedge clk);
    check("R2 pending frames", 32'(exp_q.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule